// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers seven active-high interrupt request lines, one for each priority level from 1 to 7, and turns them into a single 3-bit pending level. Zero means that nothing is pending, and the highest set line always wins. It holds the processor's 3-bit interrupt mask and its supervisor flag. A pending level is taken only when it is above the mask. Level 7 is the exception: it ignores the mask, but it is taken once per rising edge into level 7. On acceptance the block pulses `irq_taken`, raises the mask to the accepted level and sets the supervisor flag. It then enters an acknowledge phase and shows the level being acknowledged.

During the acknowledge phase, the requesting device can return its own 8-bit vector number. It can instead ask for the fixed autovector of its level. If neither reply arrives within a fixed number of cycles, the spurious-interrupt vector is used. The resolved vector number and its byte address in the table of 4-byte entries leave the block on a valid/ready stream. The valid signal and the data stay fixed until the consumer takes them. No further request is accepted until that transfer completes. Software can overwrite the mask and the supervisor flag through a load strobe, for example when it returns from a handler.

Top module: `irq_level_ctrl`

## Requirements
- R1: `pend_level` equals the number of the highest set request line, where line bit i stands for level i+1. It is 0 when no line is set, and it follows the request lines combinationally.
- R2: When idle, a pending level from 1 to 6 is accepted only when it is strictly greater than `sr_mask`. A level at or below the mask causes no `irq_taken`.
- R3: Level 7 is accepted whatever the value of `sr_mask`, including 7.
- R4: Level 7 is accepted once for each entry into level 7. While the pending level stays at 7, no second acceptance occurs. Once the pending level has been below 7 for at least one clock, level 7 can be accepted again.
- R5: On the clock edge that accepts level L, `irq_taken` becomes 1 for exactly one cycle. At the same edge `sr_mask` and `iack_level` become L, `supervisor` becomes 1 and `iack_busy` becomes 1.
- R6: If `avec_req` is high in an acknowledge cycle and `vec_ack` is low, the vector number is 24+L.
- R7: If `vec_ack` is high in an acknowledge cycle, the vector number is `dev_vec`. This holds even when `avec_req` is also high.
- R8: If neither reply arrives, the vector number becomes 24 at the end of the 16th acknowledge cycle. This is the default timeout, and no vector is produced earlier.
- R9: `vec_addr` equals `vec_number` times 4.
- R10: The output stream works as follows:
  - `vec_valid` rises on the edge that resolves the vector.
  - While `vec_ready` is low, `vec_valid`, `vec_number` and `vec_addr` hold their values.
  - A cycle with both `vec_valid` and `vec_ready` high ends the transfer, and the block returns to idle.
- R11: No request is accepted while the acknowledge phase or the output transfer is in progress. This includes a higher level.
- R12: When `sr_load` is high at a clock edge, `sr_mask` and `supervisor` take the values of `sr_load_mask` and `sr_load_super`. No acceptance occurs at that edge.
- R13: After reset:
  - `sr_mask` is 0, and `supervisor`, `irq_taken`, `iack_busy` and `vec_valid` are 0.
  - `iack_level`, `vec_number` and `vec_addr` are 0.
  - Level 7 is ready to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 7 | Request lines; bit i requests level i+1 |
| sr_load | input | 1 | Load strobe for mask and supervisor flag |
| sr_load_mask | input | 3 | Mask value to load |
| sr_load_super | input | 1 | Supervisor value to load |
| pend_level | output | 3 | Encoded highest pending level, 0 for none |
| sr_mask | output | 3 | Current interrupt mask |
| supervisor | output | 1 | Current supervisor flag |
| irq_taken | output | 1 | One-cycle pulse on acceptance |
| iack_busy | output | 1 | Acknowledge phase in progress |
| iack_level | output | 3 | Level being (or last) acknowledged |
| vec_ack | input | 1 | Device supplies its own vector |
| dev_vec | input | 8 | Vector number from the device |
| avec_req | input | 1 | Device requests the autovector |
| vec_valid | output | 1 | Vector stream valid |
| vec_ready | input | 1 | Vector stream ready |
| vec_number | output | 8 | Resolved vector number |
| vec_addr | output | 10 | Byte address of the vector entry |

## Verification
The request lines are driven as one line alone, as several lines at once, and as a level equal to, below and above the mask. These patterns separate a correct priority encoder and a correct strict comparison from encoders that favour low lines and from compares that use "at or above". Level 7 is held for many cycles, then dropped and raised again. This shows the difference between edge acceptance and level acceptance, and it shows whether the mask bypass works. The three ways to resolve a vector are exercised separately: device vector, autovector and silence until timeout. The device vector is also sent together with an autovector request, which exposes the wrong choice of priority. The consumer then holds off for several cycles while a higher request arrives. This checks that the output stays stable and that acceptance is blocked while the block is busy.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_OUT  = 2'd2
  } irq_state_e;

  localparam int unsigned SPURIOUS_VEC = 24;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic [NUM_LEVELS-1:0] req,
  output logic [LVL_W-1:0]      level
);
  // Each stage passes on its own level if its line is set.
  // Otherwise it passes on the winner from the stages below it.
  logic [LVL_W-1:0] chain [NUM_LEVELS+1];

  assign chain[0] = '0;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_stage
    assign chain[i+1] = req[i] ? LVL_W'(i + 1) : chain[i];
  end

  assign level = chain[NUM_LEVELS];
endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int unsigned TIMEOUT = 16,
  parameter int unsigned CNT_W   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select #(
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned SPUR_VEC  = 24
) (
  input  logic             active,
  input  logic [LVL_W-1:0] level,
  input  logic             dev_ack,
  input  logic [VEC_W-1:0] dev_vec,
  input  logic             auto_req,
  input  logic             expired,
  output logic             resolve,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);

  // Priority order: device vector, then autovector, then spurious on timeout.
  always_comb begin
    resolve = 1'b0;
    vec     = SPUR;
    if (active) begin
      if (dev_ack) begin
        resolve = 1'b1;
        vec     = dev_vec;
      end else if (auto_req) begin
        resolve = 1'b1;
        vec     = SPUR + VEC_W'(level);
      end else if (expired) begin
        resolve = 1'b1;
        vec     = SPUR;
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LEVELS  = 7,
  parameter int unsigned LVL_W       = $clog2(NUM_LEVELS + 1),
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned ACK_TIMEOUT = 16,
  parameter int unsigned ADDR_W      = VEC_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  sr_load,
  input  logic [LVL_W-1:0]      sr_load_mask,
  input  logic                  sr_load_super,
  output logic [LVL_W-1:0]      pend_level,
  output logic [LVL_W-1:0]      sr_mask,
  output logic                  supervisor,
  output logic                  irq_taken,
  output logic                  iack_busy,
  output logic [LVL_W-1:0]      iack_level,
  input  logic                  vec_ack,
  input  logic [VEC_W-1:0]      dev_vec,
  input  logic                  avec_req,
  output logic                  vec_valid,
  input  logic                  vec_ready,
  output logic [VEC_W-1:0]      vec_number,
  output logic [ADDR_W-1:0]     vec_addr
);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LEVELS);

  irq_state_e       state_q;
  logic [LVL_W-1:0] mask_q;
  logic             super_q;
  logic             nmi_armed_q;
  logic             taken_q;
  logic [LVL_W-1:0] ack_lvl_q;
  logic [VEC_W-1:0] vec_q;

  logic             idle;
  logic             accept_nmi;
  logic             accept_masked;
  logic             accept;
  logic             expired;
  logic             resolve;
  logic [VEC_W-1:0] sel_vec;

  irq_prio_enc #(
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_enc (
    .req  (irq_req),
    .level(pend_level)
  );

  assign idle          = (state_q == ST_IDLE);
  assign accept_nmi    = (pend_level == NMI_LVL) && nmi_armed_q;
  assign accept_masked = (pend_level != NMI_LVL) && (pend_level > mask_q);
  assign accept        = idle && !sr_load && (accept_nmi || accept_masked);

  irq_ack_timer #(
    .TIMEOUT(ACK_TIMEOUT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .run    (state_q == ST_ACK),
    .expired(expired)
  );

  irq_vec_select #(
    .LVL_W   (LVL_W),
    .VEC_W   (VEC_W),
    .SPUR_VEC(SPURIOUS_VEC)
  ) u_sel (
    .active  (state_q == ST_ACK),
    .level   (ack_lvl_q),
    .dev_ack (vec_ack),
    .dev_vec (dev_vec),
    .auto_req(avec_req),
    .expired (expired),
    .resolve (resolve),
    .vec     (sel_vec)
  );

  // Status register: a software load wins over acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      super_q <= 1'b0;
    end else if (sr_load) begin
      mask_q  <= sr_load_mask;
      super_q <= sr_load_super;
    end else if (accept) begin
      mask_q  <= pend_level;
      super_q <= 1'b1;
    end
  end

  // Level 7 is taken once per entry into level 7.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_armed_q <= 1'b1;
    end else if (pend_level != NMI_LVL) begin
      nmi_armed_q <= 1'b1;
    end else if (accept) begin
      nmi_armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      taken_q   <= 1'b0;
      ack_lvl_q <= '0;
      vec_q     <= '0;
    end else begin
      taken_q <= accept;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ack_lvl_q <= pend_level;
            state_q   <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (resolve) begin
            vec_q   <= sel_vec;
            state_q <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (vec_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sr_mask    = mask_q;
  assign supervisor = super_q;
  assign irq_taken  = taken_q;
  assign iack_busy  = (state_q == ST_ACK);
  assign iack_level = ack_lvl_q;
  assign vec_valid  = (state_q == ST_OUT);
  assign vec_number = vec_q;
  assign vec_addr   = {vec_q, 2'b00};
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = VEC_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  pend_level,
  input logic [LVL_W-1:0]  sr_mask,
  input logic              supervisor,
  input logic              irq_taken,
  input logic              iack_busy,
  input logic [LVL_W-1:0]  iack_level,
  input logic              vec_ack,
  input logic              avec_req,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [VEC_W-1:0]  vec_number,
  input logic [ADDR_W-1:0] vec_addr
);
  // R5
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> !irq_taken);

  // R5
  taken_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> supervisor && iack_busy && (sr_mask == iack_level));

  // R1
  taken_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> (iack_level == $past(pend_level)));

  // R2
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && (iack_level != '1)) |-> (iack_level > $past(sr_mask)));

  // R10
  hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=>
      (vec_valid && $stable(vec_number) && $stable(vec_addr)));

  // R6
  autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_valid) && $past(avec_req) && !$past(vec_ack)) |->
      (vec_number == (VEC_W'(24) + VEC_W'(iack_level))));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_busy || vec_valid) |=> !irq_taken || $past(iack_busy) == 1'b0);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .LVL_W (LVL_W),
  .VEC_W (VEC_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_level(pend_level),
  .sr_mask   (sr_mask),
  .supervisor(supervisor),
  .irq_taken (irq_taken),
  .iack_busy (iack_busy),
  .iack_level(iack_level),
  .vec_ack   (vec_ack),
  .avec_req  (avec_req),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .vec_number(vec_number),
  .vec_addr  (vec_addr)
);

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int TO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_req = '0;
  logic       sr_load = 1'b0;
  logic [2:0] sr_load_mask = '0;
  logic       sr_load_super = 1'b0;
  logic       vec_ack = 1'b0;
  logic [7:0] dev_vec = '0;
  logic       avec_req = 1'b0;
  logic       vec_ready = 1'b1;
  logic [2:0] pend_level, sr_mask, iack_level;
  logic       supervisor, irq_taken, iack_busy, vec_valid;
  logic [7:0] vec_number;
  logic [9:0] vec_addr;

  irq_level_ctrl #(.ACK_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sr_load(sr_load),
    .sr_load_mask(sr_load_mask), .sr_load_super(sr_load_super),
    .pend_level(pend_level), .sr_mask(sr_mask), .supervisor(supervisor),
    .irq_taken(irq_taken), .iack_busy(iack_busy), .iack_level(iack_level),
    .vec_ack(vec_ack), .dev_vec(dev_vec), .avec_req(avec_req),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_number(vec_number),
    .vec_addr(vec_addr)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int m_state = 0, m_mask = 0, m_sup = 0, m_armed = 1, m_taken = 0;
  int m_lvl = 0, m_timer = 0, m_vec = 0;

  // observed events
  int n_taken = 0, n_vec = 0, last_vec = -1, last_addr = -1;

  function automatic int pend_of(logic [6:0] r);
    int p = 0;
    for (int i = 0; i < 7; i++) if (r[i]) p = i + 1;
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    int p;
    bit acc;
    p = pend_of(irq_req);
    cycles++;
    started = 1;
    m_taken = 0;
    if (!rst_n) begin
      m_state = 0; m_mask = 0; m_sup = 0; m_armed = 1;
      m_lvl = 0; m_timer = 0; m_vec = 0;
    end else begin
      acc = (m_state == 0) && !sr_load &&
            ((p == 7 && m_armed == 1) || (p != 7 && p > m_mask));
      if (p != 7) m_armed = 1;
      else if (acc) m_armed = 0;
      if (sr_load) begin
        m_mask = int'(sr_load_mask);
        m_sup = int'(sr_load_super);
      end
      case (m_state)
        0: if (acc) begin
             m_taken = 1; m_mask = p; m_sup = 1; m_lvl = p;
             m_timer = 0; m_state = 1;
           end
        1: begin
             if (vec_ack) begin m_vec = int'(dev_vec); m_state = 2; end
             else if (avec_req) begin m_vec = 24 + m_lvl; m_state = 2; end
             else if (m_timer == TO - 1) begin m_vec = 24; m_state = 2; end
             else m_timer++;
           end
        default: if (vec_ready) m_state = 0;
      endcase
    end
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (started) begin
      check(int'(pend_level) == pend_of(irq_req), "R1 pend_level", int'(pend_level), pend_of(irq_req));
      check(int'(irq_taken) == m_taken, "R2 irq_taken", int'(irq_taken), m_taken);
      check(int'(sr_mask) == m_mask, "R5 sr_mask", int'(sr_mask), m_mask);
      check(int'(supervisor) == m_sup, "R5 supervisor", int'(supervisor), m_sup);
      check(int'(iack_busy) == int'(m_state == 1), "R11 iack_busy", int'(iack_busy), int'(m_state == 1));
      check(int'(iack_level) == m_lvl, "R5 iack_level", int'(iack_level), m_lvl);
      check(int'(vec_valid) == int'(m_state == 2), "R10 vec_valid", int'(vec_valid), int'(m_state == 2));
      check(int'(vec_number) == m_vec, "R6 vec_number", int'(vec_number), m_vec);
      check(int'(vec_addr) == m_vec * 4, "R9 vec_addr", int'(vec_addr), m_vec * 4);
      if (irq_taken) n_taken++;
      if (vec_valid && vec_ready) begin
        n_vec++;
        last_vec = int'(vec_number);
        last_addr = int'(vec_addr);
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic load_sr(input int m, input bit s);
    sr_load = 1'b1; sr_load_mask = 3'(m); sr_load_super = s;
    tick();
    sr_load = 1'b0;
  endtask

  initial begin
    int t0;
    tick(3);
    @(negedge clk);
    // R13 reset state
    check(sr_mask == 0 && !supervisor && !irq_taken && !iack_busy && !vec_valid
          && vec_number == 0 && vec_addr == 0, "R13 reset", int'(sr_mask), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(2);

    // single level 3, autovector
    avec_req = 1'b1;
    t0 = n_taken;
    irq_req = 7'b0000100;
    tick(6);
    check(n_taken == t0 + 1, "R2 single accept", n_taken - t0, 1);
    check(last_vec == 27, "R6 autovector level 3", last_vec, 27);
    check(last_addr == 108, "R9 address level 3", last_addr, 108);
    check(sr_mask == 3 && supervisor, "R5 mask raised", int'(sr_mask), 3);
    irq_req = '0;

    // two lines at once: levels 2 and 5
    load_sr(0, 0);
    irq_req = 7'b0010010;
    @(negedge clk);
    check(pend_level == 5, "R1 highest of two", int'(pend_level), 5);
    tick(6);
    check(last_vec == 29, "R1 vector for level 5", last_vec, 29);
    irq_req = '0;

    // equal to mask is ignored, above is taken
    load_sr(5, 0);
    t0 = n_taken;
    irq_req = 7'b0010000;
    tick(6);
    check(n_taken == t0, "R2 level equal to mask ignored", n_taken - t0, 0);
    check(sr_mask == 5 && !supervisor, "R2 state untouched", int'(sr_mask), 5);
    irq_req = 7'b0100000;
    tick(6);
    check(n_taken == t0 + 1 && last_vec == 30, "R2 level above mask", last_vec, 30);
    irq_req = '0;

    // level 7 under mask 7, device vector beats autovector
    load_sr(7, 1);
    vec_ack = 1'b1; dev_vec = 8'h40;
    t0 = n_taken;
    irq_req = 7'b1000000;
    tick(12);
    check(n_taken == t0 + 1, "R3 level 7 with mask 7 taken once (R4)", n_taken - t0, 1);
    check(last_vec == 64 && last_addr == 256, "R7 device vector", last_vec, 64);
    irq_req = 7'b0000001;
    tick();
    irq_req = 7'b1000000;
    tick(6);
    check(n_taken == t0 + 2, "R4 re-entry into level 7", n_taken - t0, 2);
    irq_req = '0;
    vec_ack = 1'b0;

    // no reply: spurious vector after timeout
    avec_req = 1'b0;
    load_sr(0, 0);
    t0 = n_vec;
    irq_req = 7'b0000001;
    tick(TO - 4);
    check(n_vec == t0, "R8 no early vector", n_vec - t0, 0);
    tick(8);
    check(n_vec == t0 + 1 && last_vec == 24, "R8 spurious vector", last_vec, 24);
    check(last_addr == 96, "R9 spurious address", last_addr, 96);
    irq_req = '0;

    // back-pressure and blocking while busy
    load_sr(0, 0);
    avec_req = 1'b1;
    vec_ready = 1'b0;
    t0 = n_taken;
    irq_req = 7'b0001000;
    tick(4);
    irq_req = 7'b0100000;
    tick(6);
    @(negedge clk);
    check(vec_valid && vec_number == 28, "R10 held under back-pressure", int'(vec_number), 28);
    check(n_taken == t0 + 1, "R11 higher level blocked while busy", n_taken - t0, 1);
    tick();
    vec_ready = 1'b1;
    tick(6);
    check(n_taken == t0 + 2 && last_vec == 30, "R11 accepted after drain", last_vec, 30);
    irq_req = '0;

    // software load during a pending request
    t0 = n_taken;
    irq_req = 7'b0000010;
    load_sr(0, 0);
    @(negedge clk);
    check(n_taken == t0 && sr_mask == 0 && !supervisor, "R12 load wins over accept", n_taken - t0, 0);
    tick(6);
    check(n_taken == t0 + 1, "R12 accepted after load", n_taken - t0, 1);
    irq_req = '0;
    tick(4);

    finish_run();
  end
endmodule